// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns the 4-bit transmit stream of a 100 Mb/s MAC into the three-level symbol stream that drives a twisted-pair line. Everything runs on one 125 MHz bit clock. A divide-by-five clock enable marks the slot in which one nibble, its transmit enable and its error flag are sampled. The MAC side drives its inputs so that they are stable whenever `nib_take` is high.

Each sampled nibble becomes a 5-bit code group. Idle fill, a two-group start delimiter and a two-group end delimiter frame each packet. An error flag substitutes a dedicated error group. Code groups are shifted out one bit per clock and XORed with an 11-stage scrambler sequence. The result is turned into transition coding (NRZI) and then into a three-level (MLT-3) level, which is presented as a 2-bit signed value.

Top module: `fe_tx_line_encoder`

## Requirements
- R1: After a synchronous active-low reset, `line_lvl` is 0 and `nib_take` is low. From the first clock after reset, `nib_take` is high for exactly one clock in every five, starting on the fifth clock.
- R2: While not in a frame, a sample with `tx_en` low yields the IDLE group 11111, whatever the value of `tx_err`.
- R3: A sample with `tx_en` high outside a frame yields J (11000). The next slot always yields K (10001), whatever its inputs. The nibbles in those two slots are therefore not sent.
- R4: Inside a frame, a sample with `tx_en` high and `tx_err` low yields the data group for the nibble. For nibble values 0 to F in order, the groups are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: Inside a frame, a sample with `tx_en` and `tx_err` both high yields the error group H (00100).
- R6: The first sample inside a frame with `tx_en` low yields T (01101). The next slot always yields R (00111), whatever its inputs, and the frame ends. A `tx_en` still high in the R slot starts a new frame at the following slot.
- R7: Each code group is sent most significant bit first, one bit per clock. The first bit is presented in the clock after the edge that sampled the nibble. The first group after reset is IDLE.
- R8: Each serial bit is XORed with the output s[10]^s[8] of an 11-bit shift register, which then shifts that output in at the bottom. This is the polynomial x^11+x^9+1. The register advances on every clock and starts at the all-ones seed after reset.
- R9: The NRZI signal, which starts at 0, toggles one clock after a scrambled 1 and holds after a scrambled 0.
- R10: The line level starts at 0 and steps through 0, +1, 0, -1 on each NRZI transition, one clock after the transition, and holds otherwise. The level is coded as 01 for +1, 00 for 0 and 11 for -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_nibble | input | 4 | Transmit data nibble |
| tx_en | input | 1 | Transmit enable |
| tx_err | input | 1 | Transmit error flag |
| nib_take | output | 1 | High in the clock whose closing edge samples the inputs |
| line_lvl | output | 2 | Signed three-level line symbol |

## Verification
The hardest cases to reach are the delimiter slots whose inputs must be ignored. One is a one-nibble frame, where `tx_en` drops in the K slot. The other is a back-to-back frame, where `tx_en` rises again in the R slot. Both are reached by timing the enable edges against `nib_take`. A long run of random frames carries the scrambler well past its 2047-bit period. The bench model tracks every stage behaviourally and compares the line level on every clock. A wrong group therefore shows up as a level mismatch within a few clocks.

// File: rtl/fe_tx_pkg.sv
// Shared constants, code groups and types for the transmit line encoder.
package fe_tx_pkg;
    localparam int NIB_W    = 4;
    localparam int GRP_W    = 5;
    localparam int SLOTS    = GRP_W;
    localparam int LFSR_W   = 11;
    localparam int LFSR_TAP = 9;

    typedef logic [GRP_W-1:0] grp_t;

    localparam grp_t GRP_IDLE = 5'b11111;
    localparam grp_t GRP_J    = 5'b11000;
    localparam grp_t GRP_K    = 5'b10001;
    localparam grp_t GRP_T    = 5'b01101;
    localparam grp_t GRP_R    = 5'b00111;
    localparam grp_t GRP_H    = 5'b00100;

    typedef enum logic [1:0] {FS_IDLE, FS_AFTER_J, FS_DATA, FS_AFTER_T} fstate_t;
    typedef enum logic [1:0] {ML_ZERO_A, ML_POS, ML_ZERO_B, ML_NEG} mlt_t;

    // Maps one data nibble to its 5-bit data code group.
    function automatic grp_t data_group(input logic [NIB_W-1:0] n);
        case (n)
            4'h0: data_group = 5'b11110;
            4'h1: data_group = 5'b01001;
            4'h2: data_group = 5'b10100;
            4'h3: data_group = 5'b10101;
            4'h4: data_group = 5'b01010;
            4'h5: data_group = 5'b01011;
            4'h6: data_group = 5'b01110;
            4'h7: data_group = 5'b01111;
            4'h8: data_group = 5'b10010;
            4'h9: data_group = 5'b10011;
            4'hA: data_group = 5'b10110;
            4'hB: data_group = 5'b10111;
            4'hC: data_group = 5'b11010;
            4'hD: data_group = 5'b11011;
            4'hE: data_group = 5'b11100;
            default: data_group = 5'b11101;
        endcase
    endfunction
endpackage

// File: rtl/fe_nibble_clock.sv
// Divide-by-SLOTS clock enable. Assumes a free-running bit clock.
// take is high in the last clock of each group period.
module fe_nibble_clock #(
    parameter int SLOTS = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic take
);
    localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [CW-1:0] phase;

    // Count bit slots inside one group period.
    always_ff @(posedge clk) begin
        if (!rst_n)                          phase <= '0;
        else if (phase == CW'(SLOTS - 1))    phase <= '0;
        else                                 phase <= phase + 1'b1;
    end

    assign take = (phase == CW'(SLOTS - 1));

    AST_TAKE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take) else $error("take repeated"); // R1
endmodule

// File: rtl/fe_group_mapper.sv
// Framing state machine and 4B/5B selection. The group output is
// combinational and is only meaningful in the clock where take is high.
// Assumes the MAC inputs are stable across that clock.
module fe_group_mapper
    import fe_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [NIB_W-1:0] nib,
    input  logic             en,
    input  logic             err,
    output grp_t             grp
);
    fstate_t st, st_nx;
    grp_t    last_grp;

    // Select the code group and the next framing state for this slot.
    always_comb begin
        st_nx = st;
        grp   = GRP_IDLE;
        case (st)
            FS_IDLE: begin
                if (en) begin
                    grp   = GRP_J;
                    st_nx = FS_AFTER_J;
                end
            end
            FS_AFTER_J: begin
                grp   = GRP_K;
                st_nx = FS_DATA;
            end
            FS_DATA: begin
                if (!en) begin
                    grp   = GRP_T;
                    st_nx = FS_AFTER_T;
                end else if (err) begin
                    grp = GRP_H;
                end else begin
                    grp = data_group(nib);
                end
            end
            default: begin
                grp   = GRP_R;
                st_nx = FS_IDLE;
            end
        endcase
    end

    // Advance the framing state once per nibble slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    st <= FS_IDLE;
        else if (take) st <= st_nx;
    end

    // Remember the last issued group, used by the delimiter checks.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_grp <= GRP_IDLE;
        else if (take) last_grp <= grp;
    end

    AST_K_AFTER_J: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last_grp == GRP_J) |-> (grp == GRP_K)) else $error("K missing"); // R3
    AST_R_AFTER_T: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last_grp == GRP_T) |-> (grp == GRP_R)) else $error("R missing"); // R6
endmodule

// File: rtl/fe_serial_scrambler.sv
// Loads a code group on take and shifts it out MSB first. Each bit is
// XORed with an LFSR key stream that advances every clock.
module fe_serial_scrambler
    import fe_tx_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  grp_t grp,
    output logic scr_bit
);
    grp_t              shreg;
    logic [LFSR_W-1:0] lfsr;
    logic              key;

    // Load a fresh group on take, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= GRP_IDLE;
        else if (take) shreg <= grp;
        else           shreg <= {shreg[GRP_W-2:0], 1'b0};
    end

    assign key = lfsr[LFSR_W-1] ^ lfsr[LFSR_TAP-1];

    // Step the scrambler register by one bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= SEED;
        else        lfsr <= {lfsr[LFSR_W-2:0], key};
    end

    assign scr_bit = shreg[GRP_W-1] ^ key;

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0) else $error("scrambler stuck at zero"); // R8
endmodule

// File: rtl/fe_line_coder.sv
// NRZI conversion followed by a three-level MLT-3 stepper. The MLT-3
// stage watches the registered NRZI signal for transitions.
module fe_line_coder
    import fe_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scr_bit,
    output logic signed [1:0] lvl
);
    logic nrzi, nrzi_d;
    mlt_t ph;

    // Toggle the NRZI line on each scrambled one.
    always_ff @(posedge clk) begin
        if (!rst_n) nrzi <= 1'b0;
        else        nrzi <= nrzi ^ scr_bit;
    end

    // Step the MLT-3 phase when the NRZI line has changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrzi_d <= 1'b0;
            ph     <= ML_ZERO_A;
        end else begin
            nrzi_d <= nrzi;
            if (nrzi != nrzi_d) ph <= mlt_t'(ph + 2'd1);
        end
    end

    // Translate the phase into a signed level.
    always_comb begin
        case (ph)
            ML_POS:  lvl = 2'sb01;
            ML_NEG:  lvl = 2'sb11;
            default: lvl = 2'sb00;
        endcase
    end

    AST_NO_POS_TO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'sb01) |=> (lvl != 2'sb11)) else $error("+1 to -1 jump"); // R10
    AST_NO_NEG_TO_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'sb11) |=> (lvl != 2'sb01)) else $error("-1 to +1 jump"); // R10
endmodule

// File: rtl/fe_tx_line_encoder.sv
// Top of the transmit line encoder. The stage order is fixed: nibble
// clock, group mapping, serializing scrambler, then NRZI and MLT-3.
module fe_tx_line_encoder
    import fe_tx_pkg::*;
#(
    parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        tx_nibble,
    input  logic              tx_en,
    input  logic              tx_err,
    output logic              nib_take,
    output logic signed [1:0] line_lvl
);
    grp_t grp;
    logic scr_bit;

    fe_nibble_clock #(.SLOTS(SLOTS)) u_clk (
        .clk(clk), .rst_n(rst_n), .take(nib_take)
    );

    fe_group_mapper u_map (
        .clk(clk), .rst_n(rst_n), .take(nib_take),
        .nib(tx_nibble), .en(tx_en), .err(tx_err), .grp(grp)
    );

    fe_serial_scrambler #(.SEED(LFSR_SEED)) u_scr (
        .clk(clk), .rst_n(rst_n), .take(nib_take), .grp(grp), .scr_bit(scr_bit)
    );

    fe_line_coder u_line (
        .clk(clk), .rst_n(rst_n), .scr_bit(scr_bit), .lvl(line_lvl)
    );
endmodule

// File: tb/fe_tx_line_encoder_test.sv
module fe_tx_line_encoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] nib = 4'h0;
    logic en = 1'b0;
    logic er = 1'b0;
    logic nib_take;
    logic signed [1:0] line_lvl;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fe_tx_line_encoder uut (
        .clk(clk), .rst_n(rst_n), .tx_nibble(nib), .tx_en(en), .tx_err(er),
        .nib_take(nib_take), .line_lvl(line_lvl)
    );

    // Reference model state
    int    m_cnt = 0;
    bit    m_q[$];
    int    m_lfsr = 0;
    bit    m_nrzi = 0, m_nrzi_d = 0;
    int    m_ph = 0;
    int    m_st = 0;
    string m_tag = "R2";
    bit    m_valid = 0;

    function automatic logic [4:0] code_of(input int n);
        logic [4:0] t [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                               5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
        return t[n];
    endfunction

    task automatic push_group(input logic [4:0] g, input string tag);
        for (int i = 4; i >= 0; i--) m_q.push_back(g[i]);
        m_tag = tag;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural model, stepped at each rising edge
    always @(posedge clk) begin
        bit b, key, s;
        if (!rst_n) begin
            m_cnt = 0; m_q.delete(); push_group(5'b11111, "R2 R7");
            m_lfsr = 'h7FF; m_nrzi = 0; m_nrzi_d = 0; m_ph = 0; m_st = 0; m_valid = 1;
        end else begin
            b = m_q.pop_front();
            key = ((m_lfsr >> 10) ^ (m_lfsr >> 8)) & 1;
            m_lfsr = ((m_lfsr << 1) | key) & 'h7FF;
            s = b ^ key;
            if (m_nrzi != m_nrzi_d) m_ph = (m_ph + 1) % 4;
            m_nrzi_d = m_nrzi;
            m_nrzi = m_nrzi ^ s;
            if (m_cnt == 4) begin
                m_cnt = 0;
                case (m_st)
                    0: if (en) begin push_group(5'b11000, "R3"); m_st = 1; end
                       else push_group(5'b11111, "R2");
                    1: begin push_group(5'b10001, "R3"); m_st = 2; end
                    2: if (!en) begin push_group(5'b01101, "R6"); m_st = 3; end
                       else if (er) push_group(5'b00100, "R5");
                       else push_group(code_of(int'(nib)), "R4");
                    default: begin push_group(5'b00111, "R6"); m_st = 0; end
                endcase
            end else begin
                m_cnt++;
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        int exp_lvl;
        if (m_valid && rst_n && !done) begin
            chk(nib_take == (m_cnt == 4), "R1 take", int'(nib_take), int'(m_cnt == 4));
            exp_lvl = (m_ph == 1) ? 1 : (m_ph == 3) ? -1 : 0;
            chk(int'(line_lvl) == exp_lvl, {"R7 R8 R9 R10 level, group ", m_tag},
                int'(line_lvl), exp_lvl);
        end
    end

    task automatic slot(input logic [3:0] n, input logic e, input logic x);
        do @(negedge clk); while (!nib_take);
        nib = n; en = e; er = x;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(line_lvl == 2'sb00, "R1 reset level", int'(line_lvl), 0);
        chk(nib_take == 1'b0, "R1 reset take", int'(nib_take), 0);
        rst_n = 1'b1;
        // R2: idle with the error flag wiggling
        for (int i = 0; i < 8; i++) slot(4'(i), 1'b0, i[0]);
        // R3 R4: preamble pair then every nibble value
        slot(4'h5, 1'b1, 1'b0); slot(4'h5, 1'b1, 1'b1);
        for (int i = 0; i < 16; i++) slot(4'(i), 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) slot(4'h0, 1'b0, 1'b0);
        // R5: errors inside a frame
        slot(4'h5, 1'b1, 1'b0); slot(4'h5, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) slot(4'(i), 1'b1, (i == 3) || (i == 5));
        // R6: inputs in the R slot ignored
        slot(4'h0, 1'b0, 1'b0); slot(4'hA, 1'b0, 1'b1);
        slot(4'h0, 1'b0, 1'b0); slot(4'h0, 1'b0, 1'b0);
        // R3: one-nibble frame, K slot input ignored
        slot(4'h3, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) slot(4'h0, 1'b0, 1'b0);
        // R6: back-to-back frames, enable high in the R slot
        for (int i = 0; i < 6; i++) slot(4'(i + 7), 1'b1, 1'b0);
        slot(4'h0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) slot(4'(i + 2), 1'b1, 1'b0);
        slot(4'h0, 1'b0, 1'b0); slot(4'h0, 1'b0, 1'b0);
        // R8: long random traffic across the scrambler period
        for (int f = 0; f < 5; f++) begin
            for (int i = 0; i < 100; i++)
                slot(4'($urandom_range(0, 15)), 1'b1, ($urandom_range(0, 19) == 0));
            for (int i = 0; i < 3; i++) slot(4'h0, 1'b0, 1'($urandom_range(0, 1)));
        end
        for (int i = 0; i < 10; i++) slot(4'h0, 1'b0, 1'b0);
        @(negedge clk);
        finish_run();
    end
endmodule